// File: doc/BRIEF.md
# Write-Through Data Cache with Posted Store Queue

This block is a 1 KB direct-mapped data cache for 32-bit word accesses. It sits between a processor port and a slower memory. The cache holds 32 lines of 32 bytes each. Every line keeps a valid flag and an address tag next to its eight data words. Reads that hit are answered in the same cycle that the request is presented. A read that misses fetches the whole line from memory before it answers.

Stores use a write-through policy. A store that hits updates the cached word, and every store, hit or miss, is also placed in a four-entry first-in first-out queue. That queue retires one word at a time to the memory write port. A store that misses leaves the cache contents unchanged. The processor waits on a store only when the queue is full. Because the cache never holds modified data, a read miss never writes anything to memory. Before a line fill is requested, the queue is emptied so that memory already holds every earlier store.

The processor holds `cpu_req` and its other request signals steady until it sees `cpu_ready` high. The access completes on the rising edge where both are high. A line fill is started with a one-cycle `mem_rd_req` pulse. Memory then returns eight words in ascending word order, one word on each cycle where `mem_rd_valid` is high.

Top module: `wtc_cache_top`

## Requirements
- R1: The address is split as tag = bits 31:10, line index = bits 9:5 and word-in-line = bits 4:2, and bits 1:0 are ignored. Two addresses with the same index and different tags displace each other. Addresses with different indexes occupy separate lines.
- R2: Reset clears every valid flag, so the first read of any address after reset misses and starts a line fill. While reset is applied, `mem_rd_req` and `mem_wr_valid` are low.
- R3: A read that hits raises `cpu_ready` in the same cycle as the request, returns the cached word on `cpu_rdata`, and causes no memory traffic.
- R4: On a read miss, `mem_rd_req` is raised only after the store queue is empty. A read that follows a store to the same address therefore returns the stored value.
- R5: A line fill requests the line-aligned address (bits 4:0 zero) and accepts eight words, where the k-th accepted word becomes word k of the line. The line then becomes valid with the new tag, and the pending read completes from the filled line.
- R6: A store that hits updates the cached word. A store that misses does not allocate a line, so a later read of that address still misses.
- R7: The store queue holds four entries. Four stores in a row are accepted with no stall while memory accepts nothing. Stores reach the memory write port in the order they were accepted, one word per cycle where `mem_wr_valid` and `mem_wr_ready` are both high, with their word-aligned address and data.
- R8: A store presented while the queue holds four entries is stalled (`cpu_ready` low) until an entry retires.
- R9: The number of memory writes equals the number of accepted stores. Reads, including read misses, never produce a memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor request, held until accepted |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access completes at this clock edge |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` on a load |
| mem_rd_req | output | 1 | One-cycle pulse that starts a line fill |
| mem_rd_addr | output | 32 | Line-aligned fill address |
| mem_rd_valid | input | 1 | A fill word is present |
| mem_rd_data | input | 32 | Fill word, in ascending word order |
| mem_wr_valid | output | 1 | Head of the store queue is present |
| mem_wr_addr | output | 32 | Word-aligned store address |
| mem_wr_data | output | 32 | Store data |
| mem_wr_ready | input | 1 | Memory takes the head entry at this edge |

## Verification
A corrupted valid flag or tag shows up at the next read of that line: either an extra or a missing `mem_rd_req`, or a word from another address on `cpu_rdata`, both in the cycle of the access. A wrong fill beat counter or wrong data write index returns wrong words on the full sweep of every line. A store-queue pointer or count fault shows up as reordered, duplicated or lost memory writes, or as a wrong stall length, when memory is held off. A missing drain check shows up as a stale value returned within one fill, because the bench's memory answers the fill from its own contents.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int LINE_BYTES = 32;
    localparam int NUM_LINES  = 32;
    localparam int WB_DEPTH   = 4;

    localparam int OFF_W          = $clog2(LINE_BYTES);
    localparam int IDX_W          = $clog2(NUM_LINES);
    localparam int TAG_W          = ADDR_W - IDX_W - OFF_W;
    localparam int BYTE_W         = $clog2(DATA_W / 8);
    localparam int WORD_W         = OFF_W - BYTE_W;
    localparam int WORDS_PER_LINE = 1 << WORD_W;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] word;
        logic [BYTE_W-1:0] bsel;
    } addr_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wb_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_ISSUE,
        ST_FILL
    } state_t;

    function automatic logic [ADDR_W-1:0] line_base(input addr_t a);
        return {a.tag, a.idx, {OFF_W{1'b0}}};
    endfunction

    function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
    endfunction
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
    parameter int LINES = 32,
    parameter int IDX_W = 5,
    parameter int TAG_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

    // R2: the cycle after reset, no line is valid
    a_r2_valid_cleared: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_q == '0));
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
    parameter int LINES  = 32,
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    parameter int WORD_W = 3
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WORD_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data
);
    localparam int ENTRIES = LINES * WORDS;

    logic [DATA_W-1:0] mem_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[{wr_idx, wr_word}] <= wr_data;
        end
    end

    assign rd_data = mem_q[{rd_idx, rd_word}];
endmodule

// File: rtl/wtc_post_fifo.sv
module wtc_post_fifo
    import wtc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  wb_entry_t push_data,
    input  logic      pop,
    output wb_entry_t head,
    output logic      full,
    output logic      empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    wb_entry_t          slot_q [DEPTH];
    logic [PTR_W-1:0]   rd_ptr_q, wr_ptr_q;
    logic [CNT_W-1:0]   count_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) begin
                wr_ptr_q <= bump(wr_ptr_q);
            end
            if (pop) begin
                rd_ptr_q <= bump(rd_ptr_q);
            end
            if (push && !pop) begin
                count_q <= count_q + 1'b1;
            end else if (pop && !push) begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slot_q[wr_ptr_q] <= push_data;
        end
    end

    assign head  = slot_q[rd_ptr_q];
    assign full  = (count_q == CNT_W'(DEPTH));
    assign empty = (count_q == '0);

    // R7: the controller never pushes into a full queue
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R7: nothing is retired from an empty queue
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/wtc_cache_top.sv
module wtc_cache_top
    import wtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ready
);
    addr_t             req_a;
    state_t            state_q, state_d;
    addr_t             miss_q;
    logic [WORD_W-1:0] beat_q;
    logic              last_beat;

    logic              line_valid;
    logic [TAG_W-1:0]  line_tag;
    logic              hit;
    logic              tag_wr_en;

    logic              dwr_en;
    logic [IDX_W-1:0]  dwr_idx;
    logic [WORD_W-1:0] dwr_word;
    logic [DATA_W-1:0] dwr_data;

    logic              wb_push, wb_pop, wb_full, wb_empty;
    wb_entry_t         wb_in, wb_head;

    assign req_a     = addr_t'(cpu_addr);
    assign hit       = line_valid && (line_tag == req_a.tag);
    assign last_beat = (beat_q == WORD_W'(WORDS_PER_LINE - 1));

    wtc_tag_store #(
        .LINES (NUM_LINES),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (req_a.idx),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .wr_en    (tag_wr_en),
        .wr_idx   (miss_q.idx),
        .wr_tag   (miss_q.tag)
    );

    wtc_data_store #(
        .LINES  (NUM_LINES),
        .WORDS  (WORDS_PER_LINE),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .WORD_W (WORD_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (dwr_en),
        .wr_idx  (dwr_idx),
        .wr_word (dwr_word),
        .wr_data (dwr_data),
        .rd_idx  (req_a.idx),
        .rd_word (req_a.word),
        .rd_data (cpu_rdata)
    );

    assign wb_in.addr = word_align(cpu_addr);
    assign wb_in.data = cpu_wdata;
    assign wb_pop     = !wb_empty && mem_wr_ready;

    wtc_post_fifo #(
        .DEPTH (WB_DEPTH)
    ) u_wbuf (
        .clk       (clk),
        .rst       (rst),
        .push      (wb_push),
        .push_data (wb_in),
        .pop       (wb_pop),
        .head      (wb_head),
        .full      (wb_full),
        .empty     (wb_empty)
    );

    assign mem_wr_valid = !wb_empty;
    assign mem_wr_addr  = wb_head.addr;
    assign mem_wr_data  = wb_head.data;
    assign mem_rd_addr  = line_base(miss_q);

    always_comb begin
        state_d    = state_q;
        cpu_ready  = 1'b0;
        wb_push    = 1'b0;
        tag_wr_en  = 1'b0;
        mem_rd_req = 1'b0;
        dwr_en     = 1'b0;
        dwr_idx    = req_a.idx;
        dwr_word   = req_a.word;
        dwr_data   = cpu_wdata;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we) begin
                        if (!wb_full) begin
                            cpu_ready = 1'b1;
                            wb_push   = 1'b1;
                            dwr_en    = hit;
                        end
                    end else if (hit) begin
                        cpu_ready = 1'b1;
                    end else begin
                        state_d = ST_DRAIN;
                    end
                end
            end
            ST_DRAIN: begin
                if (wb_empty) begin
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                mem_rd_req = 1'b1;
                state_d    = ST_FILL;
            end
            ST_FILL: begin
                dwr_idx  = miss_q.idx;
                dwr_word = beat_q;
                dwr_data = mem_rd_data;
                if (mem_rd_valid) begin
                    dwr_en = 1'b1;
                    if (last_beat) begin
                        tag_wr_en = 1'b1;
                        state_d   = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            miss_q  <= '0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_DRAIN) begin
                miss_q <= req_a;
            end
            if (state_q == ST_ISSUE) begin
                beat_q <= '0;
            end else if (state_q == ST_FILL && mem_rd_valid) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // R4: a fill is requested only with the store queue empty
    a_r4_drained_before_fill: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> wb_empty);
    // R8: a store into a full queue is held off
    a_r8_full_stalls: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && wb_full) |-> !cpu_ready);
    // R5: the processor is not answered in the cycle after a fill request
    a_r5_busy_after_request: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |=> !cpu_ready);
    // R9: a load never enters the store queue
    a_r9_load_no_post: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_we) |-> !wb_push);
endmodule

// File: tb/wtc_cache_top_tb.sv
`timescale 1ns/1ps
module wtc_cache_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_req, cpu_we;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        cpu_ready;
    logic        mem_rd_req, mem_rd_valid;
    logic [31:0] mem_rd_addr, mem_rd_data;
    logic        mem_wr_valid, mem_wr_ready;
    logic [31:0] mem_wr_addr, mem_wr_data;

    always #4 clk = ~clk;

    wtc_cache_top u_dut (
        .clk (clk), .rst (rst),
        .cpu_req (cpu_req), .cpu_we (cpu_we), .cpu_addr (cpu_addr),
        .cpu_wdata (cpu_wdata), .cpu_ready (cpu_ready), .cpu_rdata (cpu_rdata),
        .mem_rd_req (mem_rd_req), .mem_rd_addr (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid), .mem_rd_data (mem_rd_data),
        .mem_wr_valid (mem_wr_valid), .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data), .mem_wr_ready (mem_wr_ready)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [31:0] bmem    [int unsigned];
    logic [31:0] exp_mem [int unsigned];
    logic [31:0] wlog_addr [64];
    logic [31:0] wlog_data [64];
    int  wr_cnt = 0, store_cnt = 0, fill_cnt = 0, pend_err = 0, addr_err = 0;
    bit  wr_block = 0;
    int  cyc = 0;
    bit  fill_busy = 0, gap = 0;
    int  beat = 0;
    int unsigned fill_base = 0;

    function automatic logic [31:0] dflt(input int unsigned wa);
        logic [31:0] w;
        w = wa;
        return (w * 32'h9E37_79B1) ^ 32'h0F1E_2D3C;
    endfunction

    function automatic logic [31:0] mem_val(input int unsigned wa);
        if (bmem.exists(wa)) return bmem[wa];
        return dflt(wa);
    endfunction

    function automatic logic [31:0] exp_val(input logic [31:0] a);
        int unsigned wa;
        wa = a >> 2;
        if (exp_mem.exists(wa)) return exp_mem[wa];
        return dflt(wa);
    endfunction

    function automatic logic [31:0] mk(input int t, input int i, input int w);
        logic [31:0] tv, iv, wv;
        tv = t; iv = i; wv = w;
        return {tv[21:0], iv[4:0], wv[2:0], 2'b00};
    endfunction

    // memory model: drives at the falling edge, then observes the DUT
    always @(negedge clk) begin
        if (rst) begin
            mem_rd_valid = 1'b0;
            mem_rd_data  = '0;
            mem_wr_ready = 1'b0;
            fill_busy    = 0;
        end else begin
            cyc++;
            mem_wr_ready = !wr_block && (cyc % 3 != 0);
            mem_rd_valid = 1'b0;
            if (fill_busy) begin
                if (gap) begin
                    gap = 0;
                end else begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = mem_val(fill_base + beat);
                    beat++;
                    gap = (beat % 2 == 1);
                    if (beat == 8) fill_busy = 0;
                end
            end
            #1;
            if (mem_wr_valid && mem_wr_ready) begin
                bmem[mem_wr_addr >> 2] = mem_wr_data;
                wlog_addr[wr_cnt % 64] = mem_wr_addr;
                wlog_data[wr_cnt % 64] = mem_wr_data;
                wr_cnt++;
            end
            if (mem_rd_req) begin
                fill_cnt++;
                if (wr_cnt != store_cnt) pend_err++;
                if (mem_rd_addr[4:0] != 5'd0) addr_err++;
                fill_busy = 1;
                fill_base = mem_rd_addr >> 2;
                beat = 0;
                gap = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output int stalls);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        stalls = 0;
        forever begin
            #1;
            if (cpu_ready) break;
            stalls++;
            @(negedge clk);
        end
        rd = cpu_rdata;
        if (we) begin
            store_cnt++;
            exp_mem[a >> 2] = wd;
        end
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [31:0] a, input int exp_fills, input string req);
        logic [31:0] rv;
        int st, f0;
        f0 = fill_cnt;
        access(1'b0, a, 32'h0, rv, st);
        chk(rv == exp_val(a), req, rv, exp_val(a));
        chk(fill_cnt - f0 == exp_fills, req, fill_cnt - f0, exp_fills);
        if (exp_fills == 0) chk(st == 0, req, st, 0);
    endtask

    task automatic wait_drain();
        while (wr_cnt != store_cnt) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        int st;
        int base;
        rst = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (4) @(negedge clk);
        #1;
        chk(mem_rd_req == 1'b0, "R2 reset rd_req", {31'b0, mem_rd_req}, 0);
        chk(mem_wr_valid == 1'b0, "R2 reset wr_valid", {31'b0, mem_wr_valid}, 0);
        @(negedge clk);
        rst = 1'b0;

        // R2 / R5: cold miss fills the line
        rd_chk(mk(5, 3, 2), 1, "R2 cold miss");
        // R3: every word of the line now hits
        for (int w = 0; w < 8; w++) rd_chk(mk(5, 3, w), 0, "R3 hit in filled line");
        // R1: low two bits ignored
        rd_chk(mk(5, 3, 6) | 32'h3, 0, "R1 byte bits ignored");

        // R6: store hit updates the cache
        access(1'b1, mk(5, 3, 4), 32'hDEAD_0001, rv, st);
        chk(st == 0, "R6 store hit no stall", st, 0);
        rd_chk(mk(5, 3, 4), 0, "R6 store hit updates line");

        // R6 / R4: store miss leaves no line; read sees stored value
        access(1'b1, mk(9, 7, 1), 32'hBEEF_0002, rv, st);
        rd_chk(mk(9, 7, 1), 1, "R6 store miss no allocate");

        // R1: conflict and separate lines
        rd_chk(mk(6, 3, 0), 1, "R1 same index other tag misses");
        rd_chk(mk(5, 3, 0), 1, "R1 evicted line refetched");
        rd_chk(mk(5, 4, 0), 1, "R1 other index misses");
        rd_chk(mk(5, 3, 4), 0, "R1 separate index kept");

        // R7 / R8: queue depth and stall
        wait_drain();
        wr_block = 1;
        base = wr_cnt;
        for (int k = 0; k < 4; k++) begin
            access(1'b1, mk(5, 3, k), 32'hC0DE_0000 + k, rv, st);
            chk(st == 0, "R7 four stores accepted", st, 0);
        end
        fork
            begin
                repeat (10) @(negedge clk);
                wr_block = 0;
            end
        join_none
        access(1'b1, mk(8, 9, 5), 32'hC0DE_0004, rv, st);
        chk(st >= 5, "R8 fifth store stalls", st, 5);
        wait_drain();
        for (int k = 0; k < 5; k++) begin
            logic [31:0] ea, ed;
            ea = (k < 4) ? mk(5, 3, k) : mk(8, 9, 5);
            ed = 32'hC0DE_0000 + k;
            chk(wlog_addr[(base + k) % 64] == ea, "R7 write order addr",
                wlog_addr[(base + k) % 64], ea);
            chk(wlog_data[(base + k) % 64] == ed, "R7 write order data",
                wlog_data[(base + k) % 64], ed);
        end
        chk(wr_cnt == store_cnt, "R9 writes equal stores", wr_cnt, store_cnt);

        // R4: read miss behind pending stores
        wr_block = 1;
        access(1'b1, mk(5, 3, 6), 32'hFACE_0005, rv, st);
        access(1'b1, mk(11, 20, 2), 32'hFACE_0006, rv, st);
        fork
            begin
                repeat (12) @(negedge clk);
                wr_block = 0;
            end
        join_none
        rd_chk(mk(11, 20, 2), 1, "R4 read after pending store");
        rd_chk(mk(5, 3, 6), 0, "R4 hit after store hit");
        chk(pend_err == 0, "R4 no fill while queue busy", pend_err, 0);

        // R5 / R1: sweep all lines, then all words
        for (int l = 0; l < 32; l++) rd_chk(mk(40 + l, l, l % 8), 1, "R5 fill every line");
        base = wr_cnt;
        for (int l = 0; l < 32; l++)
            for (int w = 0; w < 8; w++) rd_chk(mk(40 + l, l, w), 0, "R5 every word filled");
        chk(wr_cnt == base, "R9 reads never write", wr_cnt, base);
        chk(addr_err == 0, "R5 fill address aligned", addr_err, 0);
        chk(wr_cnt == store_cnt, "R9 final write count", wr_cnt, store_cnt);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule